// File: doc/BRIEF.md
# Lane Code-Group Synchronization Ladder

This block watches the stream of decoded 8b/10b code groups arriving on one receive lane of a XAUI-style link. It decides whether the lane has locked onto code-group boundaries. Each group comes in with two flags that upstream logic has already worked out: whether the group is a comma and whether it is invalid. From these flags the block walks a state ladder. It acquires lock after a clean run of commas. Once locked, it degrades one level for every bad group and climbs back one level after a run of good groups. It drops lock only when errors outpace recovery.

The code-group input is a valid/ready stream. The block never holds the stream back in normal operation: `cg_ready` is high at all times except while `mgmt_reset` is asserted. During that time offered groups are refused and have no effect. Each accepted group (valid and ready high on a rising clock edge) causes exactly one ladder transition. Cycles with no accepted group leave the ladder unchanged. `sig_det` and `mgmt_reset` are plain level controls. `sync_ok` and the debug state code are plain status outputs that come straight from the state register.

Top module: `lane_sync_fsm`

## Requirements
- R1: After `rst_n` is released, the block is in the loss state: `dbg_state` is 0 and `sync_ok` is 0.
- R2: Starting from the loss state, four accepted commas with no invalid group among them bring the block to acquired level 1 (`dbg_state` 4). `sync_ok` goes high in the cycle after the fourth comma is accepted. While lock is being acquired, `dbg_state` counts 1, 2, 3 through the three detect states.
- R3: An invalid group accepted in a detect state (codes 1 to 3) returns the block to the loss state. A valid non-comma group in a detect state leaves the state unchanged.
- R4: A bad (invalid) group moves the block one level deeper: level 1 goes to 2, level 2 goes to 3, and level 3 goes to 4. A bad group at level 4, or in its recovery sub-state, goes to the loss state.
- R5: At levels 2, 3 and 4, a good group (valid and not a comma) enters the matching recovery sub-state. Four consecutive good groups, counted from the entry into the level, climb the block one level: recovery 2 goes to level 1, recovery 3 goes to level 2, recovery 4 goes to level 3.
- R6: A bad group in a recovery sub-state moves the block to the next deeper numbered level, and the good-group count starts again.
- R7: While the block is at an acquired level, a valid comma counts neither as good nor as bad and leaves the state unchanged.
- R8: `sync_ok` is 1 in every acquired level and every recovery sub-state (codes 4 to 10). It is 0 in the loss state and in the detect states (codes 0 to 3).
- R9: A cycle with no accepted group does not change the state.
- R10: While `sig_det` is low, the block stays in the loss state. Any change of `sig_det` between two consecutive clocks forces the loss state.
- R11: While `mgmt_reset` is high, the block is forced to the loss state and `cg_ready` is 0. Groups offered during that time have no effect.
- R12: The `dbg_state` codes are: loss 0; detect 1 to 3; level 1 is 4; level 2 is 5; recovery 2 is 6; level 3 is 7; recovery 3 is 8; level 4 is 9; recovery 4 is 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive lane clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| mgmt_reset | input | 1 | Synchronous management reset; forces the loss state |
| sig_det | input | 1 | Signal detect; high means a signal is present |
| cg_valid | input | 1 | A code group is offered this cycle |
| cg_ready | output | 1 | Block accepts groups; low only during the management reset |
| cg_is_comma | input | 1 | Offered group is a comma |
| cg_is_invalid | input | 1 | Offered group is invalid (code or disparity error) |
| sync_ok | output | 1 | Lane holds code-group synchronization |
| dbg_state | output | 4 | Current ladder state code (R12) |

## Verification
The bench targets the off-by-one risks in the two counts. A design that locks after three commas, or one that climbs after three good groups rather than four, diverges from the model on the first cycle where the two disagree. Invalid groups are placed between commas, so a design that does not restart acquisition stays in a detect state. Errors are spaced so that each one lands in a recovery sub-state, which exposes a design that loses its depth or keeps a stale good count. Commas are sent while locked, `sig_det` is toggled, and groups are offered during management reset; a design that let any of these through would move `dbg_state` away from the model's value.

// File: rtl/lsync_pkg.sv
package lsync_pkg;
  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_LOSS  = 4'd0,
    ST_DET1  = 4'd1,
    ST_DET2  = 4'd2,
    ST_DET3  = 4'd3,
    ST_LVL1  = 4'd4,
    ST_LVL2  = 4'd5,
    ST_REC2  = 4'd6,
    ST_LVL3  = 4'd7,
    ST_REC3  = 4'd8,
    ST_LVL4  = 4'd9,
    ST_REC4  = 4'd10
  } lsync_state_e;

  typedef struct packed {
    logic bad;
    logic good;
    logic comma;
  } lsync_evt_t;
endpackage

// File: rtl/lsync_sd_watch.sv
module lsync_sd_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_det,
  output logic force_loss
);
  logic sd_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sd_prev_q <= 1'b0;
    else        sd_prev_q <= sig_det;
  end

  // absent signal, or any edge on it, pins the ladder at the bottom
  assign force_loss = !sig_det || (sig_det != sd_prev_q);
endmodule

// File: rtl/lsync_classify.sv
module lsync_classify
  import lsync_pkg::*;
(
  input  logic       take,
  input  logic       is_comma,
  input  logic       is_invalid,
  output lsync_evt_t evt
);
  always_comb begin
    evt.bad   = take && is_invalid;
    evt.comma = take && !is_invalid && is_comma;
    evt.good  = take && !is_invalid && !is_comma;
  end
endmodule

// File: rtl/lsync_ladder_next.sv
module lsync_ladder_next
  import lsync_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  lsync_state_e     cur,
  input  logic [CNT_W-1:0] cnt,
  input  lsync_evt_t       evt,
  output lsync_state_e     nxt,
  output logic [CNT_W-1:0] nxt_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  always_comb begin
    nxt     = cur;
    nxt_cnt = cnt;
    unique case (cur)
      ST_LOSS: if (evt.comma) nxt = ST_DET1;
      ST_DET1: if (evt.bad) nxt = ST_LOSS; else if (evt.comma) nxt = ST_DET2;
      ST_DET2: if (evt.bad) nxt = ST_LOSS; else if (evt.comma) nxt = ST_DET3;
      ST_DET3: if (evt.bad) nxt = ST_LOSS; else if (evt.comma) nxt = ST_LVL1;
      ST_LVL1: if (evt.bad) begin nxt = ST_LVL2; nxt_cnt = CNT_ZERO; end
      ST_LVL2: begin
        if (evt.bad)       begin nxt = ST_LVL3; nxt_cnt = CNT_ZERO; end
        else if (evt.good) begin nxt = ST_REC2; nxt_cnt = CNT_ONE;  end
      end
      ST_LVL3: begin
        if (evt.bad)       begin nxt = ST_LVL4; nxt_cnt = CNT_ZERO; end
        else if (evt.good) begin nxt = ST_REC3; nxt_cnt = CNT_ONE;  end
      end
      ST_LVL4: begin
        if (evt.bad)       begin nxt = ST_LOSS; nxt_cnt = CNT_ZERO; end
        else if (evt.good) begin nxt = ST_REC4; nxt_cnt = CNT_ONE;  end
      end
      ST_REC2: begin
        if (evt.bad) begin nxt = ST_LVL3; nxt_cnt = CNT_ZERO; end
        else if (evt.good) begin
          if (cnt == CNT_MAX) begin nxt = ST_LVL1; nxt_cnt = CNT_ZERO; end
          else nxt_cnt = cnt + CNT_ONE;
        end
      end
      ST_REC3: begin
        if (evt.bad) begin nxt = ST_LVL4; nxt_cnt = CNT_ZERO; end
        else if (evt.good) begin
          if (cnt == CNT_MAX) begin nxt = ST_LVL2; nxt_cnt = CNT_ZERO; end
          else nxt_cnt = cnt + CNT_ONE;
        end
      end
      ST_REC4: begin
        if (evt.bad) begin nxt = ST_LOSS; nxt_cnt = CNT_ZERO; end
        else if (evt.good) begin
          if (cnt == CNT_MAX) begin nxt = ST_LVL3; nxt_cnt = CNT_ZERO; end
          else nxt_cnt = cnt + CNT_ONE;
        end
      end
      default: begin nxt = ST_LOSS; nxt_cnt = CNT_ZERO; end
    endcase
  end
endmodule

// File: rtl/lane_sync_fsm.sv
module lane_sync_fsm
  import lsync_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mgmt_reset,
  input  logic               sig_det,
  input  logic               cg_valid,
  output logic               cg_ready,
  input  logic               cg_is_comma,
  input  logic               cg_is_invalid,
  output logic               sync_ok,
  output logic [STATE_W-1:0] dbg_state
);
  lsync_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             force_loss;
  logic             take;
  lsync_evt_t       evt;

  assign cg_ready = !mgmt_reset;
  assign take     = cg_valid && cg_ready;

  lsync_sd_watch u_sd (
    .clk        (clk),
    .rst_n      (rst_n),
    .sig_det    (sig_det),
    .force_loss (force_loss)
  );

  lsync_classify u_cls (
    .take       (take),
    .is_comma   (cg_is_comma),
    .is_invalid (cg_is_invalid),
    .evt        (evt)
  );

  lsync_ladder_next #(.CNT_W(CNT_W)) u_nxt (
    .cur     (state_q),
    .cnt     (cnt_q),
    .evt     (evt),
    .nxt     (state_d),
    .nxt_cnt (cnt_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOSS;
      cnt_q   <= '0;
    end else if (mgmt_reset || force_loss) begin
      state_q <= ST_LOSS;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign dbg_state = state_q;
  assign sync_ok   = (state_q != ST_LOSS) && (state_q != ST_DET1) &&
                     (state_q != ST_DET2) && (state_q != ST_DET3);
endmodule

// File: rtl/lsync_chk.sv
module lsync_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mgmt_reset,
  input logic       sig_det,
  input logic       cg_valid,
  input logic       cg_ready,
  input logic       cg_is_comma,
  input logic       cg_is_invalid,
  input logic       sync_ok,
  input logic [3:0] dbg_state
);
  logic sd_seen_q;
  logic quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sd_seen_q <= 1'b0;
    else        sd_seen_q <= sig_det;
  end

  assign quiet = sig_det && (sd_seen_q == sig_det) && !mgmt_reset;

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_state <= 4'd10); // R12

  AST_LOCK_ON_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_ok) |-> $past(cg_valid && cg_is_comma && !cg_is_invalid)); // R2

  AST_DETECT_ERR_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (cg_valid && cg_ready && cg_is_invalid && dbg_state >= 4'd1 && dbg_state <= 4'd3)
    |=> (dbg_state == 4'd0)); // R3

  AST_BAD_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && cg_valid && cg_is_invalid && dbg_state >= 4'd4 && dbg_state <= 4'd8)
    |=> (dbg_state == 4'd5 || dbg_state == 4'd7 || dbg_state == 4'd9)); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !cg_valid) |=> $stable(dbg_state)); // R9

  AST_NO_SIGNAL_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_det |=> (dbg_state == 4'd0 && !sync_ok)); // R10

  AST_MGMT_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_reset |=> (dbg_state == 4'd0)); // R11
endmodule

bind lane_sync_fsm lsync_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mgmt_reset    (mgmt_reset),
  .sig_det       (sig_det),
  .cg_valid      (cg_valid),
  .cg_ready      (cg_ready),
  .cg_is_comma   (cg_is_comma),
  .cg_is_invalid (cg_is_invalid),
  .sync_ok       (sync_ok),
  .dbg_state     (dbg_state)
);

// File: tb/sim_lane_sync_fsm.sv
module sim_lane_sync_fsm;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mgmt_reset = 1'b0;
  logic       sig_det = 1'b1;
  logic       cg_valid = 1'b0;
  logic       cg_is_comma = 1'b0;
  logic       cg_is_invalid = 1'b0;
  logic       cg_ready;
  logic       sync_ok;
  logic [3:0] dbg_state;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_st = 0;
  int m_cnt = 0;
  bit m_sdp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_sync_fsm u0 (
    .clk(clk), .rst_n(rst_n), .mgmt_reset(mgmt_reset), .sig_det(sig_det),
    .cg_valid(cg_valid), .cg_ready(cg_ready), .cg_is_comma(cg_is_comma),
    .cg_is_invalid(cg_is_invalid), .sync_ok(sync_ok), .dbg_state(dbg_state)
  );

  // behavioural reference, one step per rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_sdp = 1'b0;
    end else begin
      bit acc, cm, bd, gd;
      acc = cg_valid && !mgmt_reset;
      bd  = acc && cg_is_invalid;
      cm  = acc && !cg_is_invalid && cg_is_comma;
      gd  = acc && !cg_is_invalid && !cg_is_comma;
      if (mgmt_reset || !sig_det || (sig_det != m_sdp)) begin
        m_st = 0; m_cnt = 0;
      end else if (m_st == 0) begin
        if (cm) m_st = 1;
      end else if (m_st <= 3) begin
        if (bd) m_st = 0; else if (cm) m_st = m_st + 1;
      end else if (m_st == 4) begin
        if (bd) begin m_st = 5; m_cnt = 0; end
      end else if (m_st == 5 || m_st == 7 || m_st == 9) begin
        if (bd) begin m_st = (m_st == 9) ? 0 : m_st + 2; m_cnt = 0; end
        else if (gd) begin m_st = m_st + 1; m_cnt = 1; end
      end else begin
        if (bd) begin m_st = (m_st == 10) ? 0 : m_st + 1; m_cnt = 0; end
        else if (gd) begin
          if (m_cnt == 3) begin m_st = (m_st == 6) ? 4 : m_st - 3; m_cnt = 0; end
          else m_cnt = m_cnt + 1;
        end
      end
      m_sdp = sig_det;
    end
  end

  // every-cycle comparison, away from the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      n_checks++;
      if (dbg_state != m_st[3:0]) begin
        n_fail++;
        $display("FAIL R12 state t=%0t actual=%0d expected=%0d", $time, dbg_state, m_st);
      end
      n_checks++;
      if (sync_ok != (m_st >= 4)) begin
        n_fail++;
        $display("FAIL R8 sync_ok t=%0t actual=%0b expected=%0b", $time, sync_ok, m_st >= 4);
      end
      n_checks++;
      if (cg_ready != !mgmt_reset) begin
        n_fail++;
        $display("FAIL R11 ready t=%0t actual=%0b expected=%0b", $time, cg_ready, !mgmt_reset);
      end
    end
  end

  task automatic grp(input bit c, input bit i);
    @(negedge clk);
    cg_valid = 1'b1; cg_is_comma = c; cg_is_invalid = i;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cg_valid = 1'b0; cg_is_comma = 1'b0; cg_is_invalid = 1'b0;
    end
  endtask

  task automatic expect_st(input int exp, input bit exp_sync, input string req);
    @(posedge clk);
    #(CLK_PERIOD/4 + 1);
    n_checks++;
    if (dbg_state != exp[3:0] || sync_ok != exp_sync) begin
      n_fail++;
      $display("FAIL %s actual=%0d/%0b expected=%0d/%0b", req, dbg_state, sync_ok, exp, exp_sync);
    end
  endtask

  task automatic acquire();
    grp(1, 0); expect_st(1, 0, "R2 det1");
    grp(1, 0); expect_st(2, 0, "R2 det2");
    grp(1, 0); expect_st(3, 0, "R2 det3");
    grp(1, 0); expect_st(4, 1, "R2 locked");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    expect_st(0, 0, "R1 reset");
    idle(3);
    expect_st(0, 0, "R9 idle in loss");

    // interrupted comma run
    grp(1, 0); grp(1, 0); expect_st(2, 0, "R3 pre");
    grp(1, 1); expect_st(0, 0, "R3 invalid in detect");
    grp(1, 0); grp(1, 0);
    grp(0, 0); expect_st(2, 0, "R3 data holds detect");
    grp(1, 0); grp(1, 0); expect_st(4, 1, "R2 lock after four");

    // one error, four good groups
    grp(0, 1); expect_st(5, 1, "R4 lvl1 to lvl2");
    grp(1, 0); expect_st(5, 1, "R7 comma ignored");
    grp(0, 0); expect_st(6, 1, "R5 enter rec2");
    grp(0, 0); grp(0, 0); expect_st(6, 1, "R5 third good");
    grp(0, 0); expect_st(4, 1, "R5 climb to lvl1");
    grp(1, 0); expect_st(4, 1, "R7 comma at lvl1");

    // spaced errors
    grp(0, 1); grp(0, 0);
    grp(0, 1); expect_st(7, 1, "R6 rec2 to lvl3");
    idle(3); expect_st(7, 1, "R9 idle holds");
    grp(0, 0); grp(0, 0); grp(0, 0); expect_st(8, 1, "R5 rec3");
    grp(0, 0); expect_st(5, 1, "R5 rec3 climbs");
    grp(0, 1); expect_st(7, 1, "R4 lvl2 to lvl3");
    grp(0, 0); grp(0, 1); expect_st(9, 1, "R6 rec3 to lvl4");
    grp(0, 0); expect_st(10, 1, "R5 enter rec4");
    grp(0, 1); expect_st(0, 0, "R4 rec4 to loss");
    idle(1);

    // signal detect
    acquire();
    idle(1);
    sig_det = 1'b0; expect_st(0, 0, "R10 drop");
    grp(1, 0); grp(1, 0); expect_st(0, 0, "R10 held while absent");
    @(negedge clk); sig_det = 1'b1; cg_valid = 1'b1; cg_is_comma = 1'b1;
    expect_st(0, 0, "R10 edge forces loss");
    acquire();

    // management reset
    @(negedge clk); cg_valid = 1'b0; mgmt_reset = 1'b1;
    expect_st(0, 0, "R11 forced");
    n_checks++;
    if (cg_ready !== 1'b0) begin
      n_fail++; $display("FAIL R11 ready actual=%0b expected=0", cg_ready);
    end
    grp(1, 0); expect_st(0, 0, "R11 group refused");
    @(negedge clk); mgmt_reset = 1'b0; cg_valid = 1'b0;
    acquire();
    idle(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule